// File: doc/BRIEF.md
# Multiplexed Host-Bus Transaction Engine

This block carries single read and write accesses from an on-chip requester to an external parallel device over one shared address/data bus of 8 or 16 bits. Every access starts with an address phase: the address is driven onto the bus and an address-latch strobe tells an external latch to capture it. A data phase follows. In that phase the read or write strobe is held low for a programmed number of wait cycles. For a write the bus carries the write data. For a read the bus driver is released, and the returned value is captured just before the read strobe rises.

The engine moves only on system clocks where the external bus-clock enable is high, so a clock generator outside the block sets the external timing. Requests arrive on a valid/ready port. A request is taken on a clock where both `req_valid` and `req_ready` are high. `req_ready` is high only while the engine is idle, and a requester must hold its request stable until it is taken. The response side has no back-pressure: `rsp_valid` is a single-clock pulse, and `rsp_rdata` holds the captured read value. A configuration code selects how many active-low chip selects are in use. Separate 2-bit coarse and 1-bit fine wait fields set the read and write data-phase lengths.

Top module: `hbus_mux_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle. It falls on the clock after a request is taken and stays low until the access, including its gap cycle, is complete. Out of reset `req_ready` is high, all strobes are inactive and `rsp_valid` is low.
- R2: The sequence advances only on clocks where `bus_ce` is high. `hb_ale` is high for exactly one enabled cycle per access. While `hb_ale` is high, the bus is driven (`hb_ad_oe`=1) with the request address.
- R3: The data phase lasts N enabled cycles, with N = 2*coarse + 2 - fine (coarse 0..3, fine 0/1, so N is 1..8). Reads use `cfg_rd_ws`/`cfg_rd_fine` and writes use `cfg_wr_ws`/`cfg_wr_fine`. The active strobe is low for exactly those N enabled cycles.
- R4: During a write data phase `hb_wr_n` is low and the bus is driven with the write data. During a read data phase `hb_rd_n` is low and `hb_ad_oe` is 0.
- R5: For a read, `rsp_rdata` receives `hb_ad_in` as sampled on the enabled clock edge that ends the last data-phase cycle.
- R6: `rsp_valid` is high for exactly one system clock per access, beginning on the clock after the data phase ends.
- R7: `cfg_pin_mode` selects the chip-select setup. 2'b00 means ALE only, with every `hb_cs_n` bit held high. 2'b01 means two selects: `req_cs[0]` picks `hb_cs_n[0]` or `hb_cs_n[1]`, and `req_cs[1]` is ignored. 2'b10 means four selects: `req_cs` picks `hb_cs_n[req_cs]`. 2'b11 acts as 2'b00. At most one select is low at a time.
- R8: The selected chip select is low throughout both the address and the data phase. All chip selects are high for at least one enabled cycle after the data phase, and they are high while `rsp_valid` is high.
- R9: `cfg_err` is high exactly when `cfg_burst` is high and the read or the write wait setting gives N greater than 1.
- R10: `hb_rd_n` and `hb_wr_n` are never low together, and neither is low while `hb_ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ce | input | 1 | Bus-clock enable; the engine steps only when high |
| cfg_pin_mode | input | 2 | Chip-select setup code (R7) |
| cfg_rd_ws | input | 2 | Read wait coarse code |
| cfg_rd_fine | input | 1 | Read wait fine modifier |
| cfg_wr_ws | input | 2 | Write wait coarse code |
| cfg_wr_fine | input | 1 | Write wait fine modifier |
| cfg_burst | input | 1 | Burst flag, checked only for conflict with wait settings |
| cfg_err | output | 1 | Wait setting conflicts with the burst flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Chip-select index |
| req_addr | input | BUS_W | Access address |
| req_wdata | input | BUS_W | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | BUS_W | Captured read data |
| hb_ad_in | input | BUS_W | Bus value from the pads |
| hb_ad_out | output | BUS_W | Bus value to the pads |
| hb_ad_oe | output | 1 | Bus output enable |
| hb_ale | output | 1 | Address-latch strobe, active high |
| hb_rd_n | output | 1 | Read strobe, active low |
| hb_wr_n | output | 1 | Write strobe, active low |
| hb_cs_n | output | NUM_CS | Chip selects, active low |

## Verification
The assertions assume that the requester keeps `req_valid` and its fields steady until the request is taken. They also assume that the configuration inputs do not change while an access is in flight. The bench changes configuration and request fields only while `req_ready` is observed high, and it drops `req_valid` on the clock after acceptance. The bus enable is driven either constantly high or high on every third clock. This covers both back-to-back stepping and stepping stalled for several clocks, so the stall properties see long held states. The read device model changes `hb_ad_in` on every enabled cycle of a read data phase, so only a capture on the final cycle returns the expected word.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_GAP  = 3'd4
  } hb_state_e;

  localparam logic [1:0] PM_ALE_ONLY = 2'b00;
  localparam logic [1:0] PM_TWO_CS   = 2'b01;
  localparam logic [1:0] PM_FOUR_CS  = 2'b10;

  localparam int WS_CODE_W = 2;
  localparam int WS_CNT_W  = 4;

  // data-phase length in enabled cycles: 2*code + 2 - fine
  function automatic logic [WS_CNT_W-1:0] ws_cycles(
    input logic [WS_CODE_W-1:0] code,
    input logic                 fine
  );
    ws_cycles = {1'b0, code, 1'b0} + WS_CNT_W'(2) - WS_CNT_W'(fine);
  endfunction

endpackage

// File: rtl/hbus_wait_cfg.sv
module hbus_wait_cfg
  import hbus_pkg::*;
(
  input  logic [WS_CODE_W-1:0] rd_code,
  input  logic                 rd_fine,
  input  logic [WS_CODE_W-1:0] wr_code,
  input  logic                 wr_fine,
  input  logic                 burst,
  output logic [WS_CNT_W-1:0]  rd_cycles,
  output logic [WS_CNT_W-1:0]  wr_cycles,
  output logic                 cfg_err
);

  assign rd_cycles = ws_cycles(rd_code, rd_fine);
  assign wr_cycles = ws_cycles(wr_code, wr_fine);

  // any stretch beyond the minimum single cycle clashes with burst
  assign cfg_err = burst &&
                   ((rd_cycles > WS_CNT_W'(1)) || (wr_cycles > WS_CNT_W'(1)));

endmodule

// File: rtl/hbus_cs_decode.sv
module hbus_cs_decode
  import hbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [1:0]        pin_mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [NUM_CS-1:0] sel
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    if (g < 2) begin : g_low
      assign sel[g] = (pin_mode == PM_FOUR_CS) ? (idx == IDX_W'(g)) :
                      (pin_mode == PM_TWO_CS)  ? (idx[0] == 1'(g))  :
                                                 1'b0;
    end else begin : g_high
      assign sel[g] = (pin_mode == PM_FOUR_CS) && (idx == IDX_W'(g));
    end
  end

endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int NUM_CS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_ce,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [BUS_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]    req_wdata,
  input  logic [NUM_CS-1:0]   req_sel,
  input  logic [WS_CNT_W-1:0] req_cycles,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [BUS_W-1:0]    rsp_rdata,
  input  logic [BUS_W-1:0]    bus_in,
  output logic [BUS_W-1:0]    bus_out,
  output logic                bus_oe,
  output logic                ale,
  output logic                rd_n,
  output logic                wr_n,
  output logic [NUM_CS-1:0]   cs_n
);

  hb_state_e            state_q;
  logic [BUS_W-1:0]     addr_q;
  logic [BUS_W-1:0]     wdata_q;
  logic                 write_q;
  logic [NUM_CS-1:0]    sel_q;
  logic [WS_CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      sel_q     <= '0;
      cnt_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            sel_q   <= req_sel;
            cnt_q   <= req_cycles - WS_CNT_W'(1);
            state_q <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (bus_ce) state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          if (bus_ce) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (bus_ce) begin
            if (cnt_q == '0) begin
              state_q   <= ST_GAP;
              rsp_valid <= 1'b1;
              if (!write_q) rsp_rdata <= bus_in;
            end else begin
              cnt_q <= cnt_q - WS_CNT_W'(1);
            end
          end
        end
        ST_GAP: begin
          if (bus_ce) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic in_addr, in_data;
  assign in_addr   = (state_q == ST_ADDR);
  assign in_data   = (state_q == ST_DATA);

  assign req_ready = (state_q == ST_IDLE);
  assign ale       = in_addr;
  assign bus_oe    = in_addr || (in_data && write_q);
  assign bus_out   = in_addr ? addr_q : wdata_q;
  assign rd_n      = !(in_data && !write_q);
  assign wr_n      = !(in_data && write_q);
  assign cs_n      = (in_addr || in_data) ? ~sel_q : '1;

endmodule

// File: rtl/hbus_mux_engine.sv
module hbus_mux_engine
  import hbus_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce,
  input  logic [1:0]        cfg_pin_mode,
  input  logic [1:0]        cfg_rd_ws,
  input  logic              cfg_rd_fine,
  input  logic [1:0]        cfg_wr_ws,
  input  logic              cfg_wr_fine,
  input  logic              cfg_burst,
  output logic              cfg_err,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_cs,
  input  logic [BUS_W-1:0]  req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic [BUS_W-1:0]  hb_ad_in,
  output logic [BUS_W-1:0]  hb_ad_out,
  output logic              hb_ad_oe,
  output logic              hb_ale,
  output logic              hb_rd_n,
  output logic              hb_wr_n,
  output logic [NUM_CS-1:0] hb_cs_n
);

  logic [WS_CNT_W-1:0] rd_cycles, wr_cycles, sel_cycles;
  logic [NUM_CS-1:0]   req_sel;

  hbus_wait_cfg u_wait (
    .rd_code   (cfg_rd_ws),
    .rd_fine   (cfg_rd_fine),
    .wr_code   (cfg_wr_ws),
    .wr_fine   (cfg_wr_fine),
    .burst     (cfg_burst),
    .rd_cycles (rd_cycles),
    .wr_cycles (wr_cycles),
    .cfg_err   (cfg_err)
  );

  hbus_cs_decode #(.NUM_CS(NUM_CS)) u_csdec (
    .pin_mode (cfg_pin_mode),
    .idx      (req_cs),
    .sel      (req_sel)
  );

  assign sel_cycles = req_write ? wr_cycles : rd_cycles;

  hbus_seq #(.BUS_W(BUS_W), .NUM_CS(NUM_CS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_ce     (bus_ce),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_sel    (req_sel),
    .req_cycles (sel_cycles),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .bus_in     (hb_ad_in),
    .bus_out    (hb_ad_out),
    .bus_oe     (hb_ad_oe),
    .ale        (hb_ale),
    .rd_n       (hb_rd_n),
    .wr_n       (hb_wr_n),
    .cs_n       (hb_cs_n)
  );

endmodule

// File: rtl/hbus_mux_engine_chk.sv
module hbus_mux_engine_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ce,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              hb_ad_oe,
  input logic              hb_ale,
  input logic              hb_rd_n,
  input logic              hb_wr_n,
  input logic [NUM_CS-1:0] hb_cs_n
);

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_ale && bus_ce) |=> !hb_ale);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ce && !req_ready) |=> ($stable(hb_ale) && $stable(hb_rd_n) && $stable(hb_wr_n)));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!hb_rd_n && !hb_wr_n));

  // R10
  ale_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_ale |-> (hb_rd_n && hb_wr_n));

  // R4
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_rd_n |-> !hb_ad_oe);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~hb_cs_n));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_ale || !hb_rd_n || !hb_wr_n) |-> !req_ready);

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&hb_cs_n));

endmodule

bind hbus_mux_engine hbus_mux_engine_chk #(.NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/hbus_mux_engine_bench.sv
module hbus_mux_engine_bench;

  localparam int BUS_W  = 16;
  localparam int NUM_CS = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_ce;
  logic [1:0]        cfg_pin_mode;
  logic [1:0]        cfg_rd_ws, cfg_wr_ws;
  logic              cfg_rd_fine, cfg_wr_fine, cfg_burst;
  logic              cfg_err;
  logic              req_valid, req_ready, req_write;
  logic [1:0]        req_cs;
  logic [BUS_W-1:0]  req_addr, req_wdata;
  logic              rsp_valid;
  logic [BUS_W-1:0]  rsp_rdata;
  logic [BUS_W-1:0]  hb_ad_in, hb_ad_out;
  logic              hb_ad_oe, hb_ale, hb_rd_n, hb_wr_n;
  logic [NUM_CS-1:0] hb_cs_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int seq_id  = 0;

  always #5 clk = ~clk;

  hbus_mux_engine #(.BUS_W(BUS_W), .NUM_CS(NUM_CS)) u_hbus_mux_engine (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce),
    .cfg_pin_mode(cfg_pin_mode), .cfg_rd_ws(cfg_rd_ws), .cfg_rd_fine(cfg_rd_fine),
    .cfg_wr_ws(cfg_wr_ws), .cfg_wr_fine(cfg_wr_fine), .cfg_burst(cfg_burst),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .hb_ad_in(hb_ad_in), .hb_ad_out(hb_ad_out), .hb_ad_oe(hb_ad_oe),
    .hb_ale(hb_ale), .hb_rd_n(hb_rd_n), .hb_wr_n(hb_wr_n), .hb_cs_n(hb_cs_n)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int cepat);
    @(negedge clk);
    cyc++;
    bus_ce = (cepat == 0) ? 1'b1 : ((cyc % 3) == 0);
  endtask

  function automatic int wait_len(input int code, input int fine);
    return 2 * code + 2 - fine;
  endfunction

  task automatic run_access(input bit wr, input int code, input int fine,
                            input int mode, input int idx, input int cepat);
    int n_exp;
    logic [BUS_W-1:0] addr, wdat, base, got;
    logic [NUM_CS-1:0] exp_cs;
    int ale_cnt, str_cnt, rsp_cnt, k;
    bit bad_addr, bad_cs, bad_dat, bad_gap, bad_rdy, bad_ex, seen_done, rd_prev, ce_prev;

    seq_id++;
    addr = BUS_W'(16'h1000 + seq_id * 7);
    wdat = ~addr;
    base = BUS_W'(16'h5A00) ^ addr;
    n_exp = wr ? wait_len(3 - code, 1 - fine) : wait_len(code, fine);
    if (mode == 2)      exp_cs = ~(NUM_CS'(1) << idx);
    else if (mode == 1) exp_cs = ~(NUM_CS'(1) << (idx % 2));
    else                exp_cs = '1;

    while (!req_ready) tick(cepat);
    cfg_pin_mode = 2'(mode);
    cfg_rd_ws    = 2'(code);
    cfg_rd_fine  = 1'(fine);
    cfg_wr_ws    = 2'(3 - code);
    cfg_wr_fine  = 1'(1 - fine);
    cfg_burst    = 1'b0;
    req_write    = wr;
    req_cs       = 2'(idx);
    req_addr     = addr;
    req_wdata    = wdat;
    req_valid    = 1'b1;
    tick(cepat);
    req_valid = 1'b0;

    ale_cnt = 0; str_cnt = 0; rsp_cnt = 0; k = 0; got = '0;
    bad_addr = 0; bad_cs = 0; bad_dat = 0; bad_gap = 0; bad_rdy = 0; bad_ex = 0;
    seen_done = 0; rd_prev = 0; ce_prev = 0;
    for (int i = 0; i < 200; i++) begin
      if (hb_ale) begin
        if (bus_ce) ale_cnt++;
        if (hb_ad_out !== addr || !hb_ad_oe) bad_addr = 1;
        if (hb_cs_n !== exp_cs) bad_cs = 1;
        if (!hb_rd_n || !hb_wr_n) bad_ex = 1;
      end
      if (!hb_rd_n || !hb_wr_n) begin
        if (bus_ce) str_cnt++;
        if (hb_cs_n !== exp_cs) bad_cs = 1;
        if (wr) begin
          if (hb_wr_n || !hb_rd_n || !hb_ad_oe || hb_ad_out !== wdat) bad_dat = 1;
        end else begin
          if (hb_rd_n || !hb_wr_n || hb_ad_oe) bad_dat = 1;
        end
      end
      if (!hb_rd_n) begin
        if (rd_prev) begin
          if (ce_prev) k++;
        end else k = 0;
        hb_ad_in = base + BUS_W'(k);
      end
      rd_prev = !hb_rd_n;
      ce_prev = bus_ce;
      if (req_ready && !seen_done) bad_rdy = 1;
      if (rsp_valid) begin
        rsp_cnt++;
        seen_done = 1;
        got = rsp_rdata;
        if (hb_cs_n !== '1) bad_gap = 1;
      end
      if (seen_done && req_ready && !rsp_valid) break;
      tick(cepat);
    end

    check(!bad_rdy && seen_done, "R1 ready low while busy", 32'(bad_rdy), 32'd0);
    check(ale_cnt == 1, "R2 ALE enabled cycles", 32'(ale_cnt), 32'd1);
    check(!bad_addr, "R2 address on bus during ALE", 32'(bad_addr), 32'd0);
    check(str_cnt == n_exp, "R3 data-phase length", 32'(str_cnt), 32'(n_exp));
    check(!bad_dat, "R4 data-phase bus and strobe", 32'(bad_dat), 32'd0);
    if (!wr)
      check(got === base + BUS_W'(n_exp - 1), "R5 read data sampled last cycle",
            32'(got), 32'(base + BUS_W'(n_exp - 1)));
    check(rsp_cnt == 1, "R6 done pulse width", 32'(rsp_cnt), 32'd1);
    check(!bad_cs, "R7 chip-select pattern", 32'(bad_cs), 32'(exp_cs));
    check(!bad_gap, "R8 selects high at completion", 32'(bad_gap), 32'd0);
    check(!bad_ex, "R10 ALE and strobes exclusive", 32'(bad_ex), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_ce = 1'b1; cfg_pin_mode = '0; cfg_rd_ws = '0; cfg_wr_ws = '0;
    cfg_rd_fine = 1'b0; cfg_wr_fine = 1'b0; cfg_burst = 1'b0; req_valid = 1'b0;
    req_write = 1'b0; req_cs = '0; req_addr = '0; req_wdata = '0; hb_ad_in = '0;
    repeat (3) tick(0);
    // R1 R8 R10 reset state
    check(req_ready === 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
    check(rsp_valid === 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check(hb_cs_n === '1, "R8 reset selects", 32'(hb_cs_n), 32'hF);
    check(hb_rd_n && hb_wr_n && !hb_ale, "R10 reset strobes",
          32'({hb_ale, hb_rd_n, hb_wr_n}), 32'b011);
    rst_n = 1'b1;
    tick(0);

    for (int cp = 0; cp < 2; cp++)
      for (int wr = 0; wr < 2; wr++)
        for (int code = 0; code < 4; code++)
          for (int fine = 0; fine < 2; fine++)
            for (int mode = 0; mode < 4; mode++)
              for (int idx = 0; idx < 4; idx++)
                run_access(1'(wr), code, fine, mode, idx, cp);

    // R9 configuration conflict sweep
    for (int b = 0; b < 2; b++)
      for (int rc = 0; rc < 4; rc++)
        for (int rf = 0; rf < 2; rf++)
          for (int wc = 0; wc < 4; wc++)
            for (int wf = 0; wf < 2; wf++) begin
              bit exp_err;
              tick(0);
              cfg_burst = 1'(b); cfg_rd_ws = 2'(rc); cfg_rd_fine = 1'(rf);
              cfg_wr_ws = 2'(wc); cfg_wr_fine = 1'(wf);
              #1;
              exp_err = (b == 1) && (wait_len(rc, rf) > 1 || wait_len(wc, wf) > 1);
              check(cfg_err === exp_err, "R9 burst/wait conflict",
                    32'(cfg_err), 32'(exp_err));
            end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule